// File: doc/BRIEF.md
# Buffered I2C Burst Master

This block is an I2C bus master that software drives through a small byte-wide register file. Software writes a one-byte target field (a 7-bit device address plus a read/write flag in its lowest bit), a length field and up to sixteen payload bytes. It then writes the control register to launch a burst. The engine produces a start condition and shifts out the target byte. It then either sends count+1 buffered bytes or clocks count+1 bytes in from the device and stores them back in the same buffer.

While the engine runs, software polls a busy flag. When the burst ends, a done flag or a fault flag tells software how it went. The bus is left held, with SCL low, after a burst. Software then either writes a release command, which produces a stop condition, or launches another burst, which produces a repeated start.

Both bus lines are open-drain. The block only ever pulls a line low or lets it go, and it reads both lines back. The bit rate is set by a quarter-period divider parameter. If SCL is released but another device still holds it low, the divider waits until the line reads high.

Top module: `i2cb_master`

## Requirements
- R1: After reset, every readable register (offsets 0x00, 0x01, 0x03 and 0x04 to 0x13) reads 0x00, and both bus lines are released (the block pulls neither SCL nor SDA low).
- R2: The length register at offset 0x00 keeps only bits 3:0 of a write and reads back as that value zero-extended. A burst moves exactly length+1 bytes, from 1 to 16.
- R3: The target register at offset 0x03 stores and reads back all 8 bits. Bits 7:1 are the 7-bit device address sent first on the bus, and bit 0 selects the direction, 1 for read and 0 for write.
- R4: Offsets 0x04 to 0x13 are payload bytes 0 to 15, written by software and read back. Offset 0x02 and offsets 0x14 to 0x1F always read 0x00.
- R5: A write of a value with bit 0 and bit 2 both set to offset 0x02 launches a burst. The burst sends a start condition (or a repeated start if the bus is held), then the target byte MSB first, then, in write direction, payload bytes 0 to length in order, each MSB first.
- R6: The status register is at offset 0x01, with bit 0 busy, bit 2 fault and bit 3 done. When every byte of a burst is acknowledged, status becomes exactly 0x08.
- R7: Status bit 0 reads 1 from the clock edge that accepts the control write until the engine finishes. While it is 1, writes to offsets 0x00, 0x02, 0x03 and 0x04 to 0x13 have no effect.
- R8: In read direction, received bytes go into payload bytes 0 to length in order. The master acknowledges each byte (SDA low in the ninth clock) except the last, which it does not acknowledge (SDA high).
- R9: A missing acknowledge on the target byte or on a written payload byte sets status bit 2 and clears bit 0. No further bytes are sent, bit 3 keeps its previous value, and no stop condition is generated.
- R10: A write to offset 0x02 with bit 0 set and bit 2 clear clears status bit 2. If the bus is held after a burst, the write also produces a stop condition. If the bus is idle, it produces no bus activity.
- R11: A write to offset 0x02 with bit 0 clear clears status bit 2 when its bit 2 is 0, and does nothing when its bit 2 is 1.
- R12: Outside start and stop conditions, SDA changes only while SCL is low. Consecutive SCL rising edges within a byte are 4*QUARTER+2 clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for reg_addr, combinational from register state |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A register write takes effect at the clock edge that samples it, so its readback, including the busy bit after a launch, is due one cycle later. The bench therefore samples every read at the following falling edge. Burst results appear only when busy drops, at an unknown but bounded time, so the bench polls status every cycle and compares the full register image with its reference model only after busy reads 0. On the bus side, a device model collects the received bytes, acknowledge bits and start/stop counts. It also times the SCL rising edges inside a byte against the 4*QUARTER+2 cycle spacing.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int REG_COUNT  = 0;
    localparam int REG_STATUS = 1;
    localparam int REG_CTRL   = 2;
    localparam int REG_ADDR   = 3;
    localparam int REG_DATA0  = 4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_BIT   = 2'd2
    } phy_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_START = 3'd1,
        SQ_ADDR  = 3'd2,
        SQ_DATA  = 3'd3,
        SQ_STOP  = 3'd4
    } seq_e;

endpackage

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
    parameter int QUARTER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic tick
);
    localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && !hold && (cnt_q == CW'(QUARTER - 1));
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (!hold) begin
            cnt_d = tick ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cb_phy.sv
module i2cb_phy
    import i2cb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  phy_op_e cmd_op,
    input  logic    cmd_bit,
    input  logic    tick,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    run,
    output logic    hold,
    output logic    done,
    output logic    rx_bit,
    output logic    cond_active,
    output logic    scl_oe,
    output logic    sda_oe
);
    typedef struct packed {
        logic    busy;
        phy_op_e op;
        logic [1:0] ph;
        logic    scl_oe;
        logic    sda_oe;
        logic    tx;
        logic    rx;
        logic    done;
    } phy_s;

    phy_s d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (cmd_valid) begin
                d.busy = 1'b1;
                d.op   = cmd_op;
                d.ph   = 2'd0;
                d.tx   = cmd_bit;
            end
        end else if (tick) begin
            d.ph = q.ph + 2'd1;
            unique case (q.op)
                OP_START: begin
                    case (q.ph)
                        2'd0: d.sda_oe = 1'b0;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: d.sda_oe = 1'b1;
                        default: begin
                            d.scl_oe = 1'b1;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                        end
                    endcase
                end
                OP_STOP: begin
                    case (q.ph)
                        2'd0: d.sda_oe = 1'b1;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: d.sda_oe = 1'b0;
                        default: begin
                            d.busy = 1'b0;
                            d.done = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (q.ph)
                        2'd0: d.sda_oe = ~q.tx;
                        2'd1: d.scl_oe = 1'b0;
                        2'd2: d.rx     = sda_i;
                        default: begin
                            d.scl_oe = 1'b1;
                            d.busy   = 1'b0;
                            d.done   = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, op: OP_BIT, ph: 2'd0, scl_oe: 1'b0,
                   sda_oe: 1'b0, tx: 1'b1, rx: 1'b1, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign run         = q.busy;
    assign hold        = q.busy && !q.scl_oe && !scl_i;
    assign done        = q.done;
    assign rx_bit      = q.rx;
    assign cond_active = q.busy && (q.op != OP_BIT);
    assign scl_oe      = q.scl_oe;
    assign sda_oe      = q.sda_oe;
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
    import i2cb_pkg::*;
#(
    parameter int NBYTES  = 16,
    parameter int QUARTER = 4,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        seq_e                   sq;
        logic [IW-1:0]          cnt;
        logic [7:0]             addr;
        logic [NBYTES-1:0][7:0] pay;
        logic                   busy;
        logic                   err;
        logic                   cmp;
        logic                   held;
        logic [IW-1:0]          idx;
        logic [3:0]             bitn;
        logic [7:0]             sh;
        logic                   issue;
        phy_op_e                op;
        logic                   tx;
    } top_s;

    top_s d, q;

    logic phy_tick, phy_run, phy_hold, phy_done, phy_rx, phy_cond;

    wire ctrl_en_wr = reg_wr && (reg_addr == ADDR_W'(REG_CTRL)) && reg_wdata[0];

    i2cb_tick #(.QUARTER(QUARTER)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phy_run),
        .hold  (phy_hold),
        .tick  (phy_tick)
    );

    i2cb_phy u_phy (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (q.issue),
        .cmd_op      (q.op),
        .cmd_bit     (q.tx),
        .tick        (phy_tick),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .run         (phy_run),
        .hold        (phy_hold),
        .done        (phy_done),
        .rx_bit      (phy_rx),
        .cond_active (phy_cond),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

    logic          rd_phase;
    logic [IW-1:0] nidx;
    logic [7:0]    nbyte;

    always_comb begin
        d        = q;
        rd_phase = (q.sq == SQ_DATA) && q.addr[0];
        nidx     = (q.sq == SQ_ADDR) ? '0 : q.idx + IW'(1);
        nbyte    = q.addr[0] ? 8'hFF : q.pay[nidx];

        if (q.issue && !phy_run) d.issue = 1'b0;

        // software writes, accepted only while the engine is idle
        if (reg_wr && !q.busy) begin
            if (reg_addr == ADDR_W'(REG_COUNT)) d.cnt = reg_wdata[IW-1:0];
            if (reg_addr == ADDR_W'(REG_ADDR))  d.addr = reg_wdata;
            for (int i = 0; i < NBYTES; i++) begin
                if (reg_addr == ADDR_W'(REG_DATA0 + i)) d.pay[i] = reg_wdata;
            end
            if (ctrl_en_wr) begin
                if (reg_wdata[2]) begin
                    d.busy  = 1'b1;
                    d.sq    = SQ_START;
                    d.idx   = '0;
                    d.issue = 1'b1;
                    d.op    = OP_START;
                end else begin
                    d.err = 1'b0;
                    if (q.held) begin
                        d.busy  = 1'b1;
                        d.sq    = SQ_STOP;
                        d.issue = 1'b1;
                        d.op    = OP_STOP;
                    end
                end
            end else if (reg_addr == ADDR_W'(REG_CTRL) && !reg_wdata[2]) begin
                d.err = 1'b0;
            end
        end

        // burst sequencer, advanced by each finished bus operation
        if (phy_done) begin
            unique case (q.sq)
                SQ_START: begin
                    d.held  = 1'b1;
                    d.sq    = SQ_ADDR;
                    d.sh    = q.addr;
                    d.bitn  = 4'd0;
                    d.issue = 1'b1;
                    d.op    = OP_BIT;
                    d.tx    = q.addr[7];
                end
                SQ_ADDR, SQ_DATA: begin
                    if (q.bitn < 4'd8) begin
                        d.sh    = {q.sh[6:0], phy_rx};
                        d.bitn  = q.bitn + 4'd1;
                        d.issue = 1'b1;
                        d.op    = OP_BIT;
                        if (q.bitn == 4'd7) begin
                            d.tx = rd_phase ? (q.idx == q.cnt) : 1'b1;
                            if (rd_phase) d.pay[q.idx] = {q.sh[6:0], phy_rx};
                        end else begin
                            d.tx = q.sh[6];
                        end
                    end else if (!rd_phase && phy_rx) begin
                        d.err  = 1'b1;
                        d.busy = 1'b0;
                        d.sq   = SQ_IDLE;
                    end else if (q.sq == SQ_DATA && q.idx == q.cnt) begin
                        d.cmp  = 1'b1;
                        d.err  = 1'b0;
                        d.busy = 1'b0;
                        d.sq   = SQ_IDLE;
                    end else begin
                        d.sq    = SQ_DATA;
                        d.idx   = nidx;
                        d.sh    = nbyte;
                        d.bitn  = 4'd0;
                        d.issue = 1'b1;
                        d.op    = OP_BIT;
                        d.tx    = nbyte[7];
                    end
                end
                SQ_STOP: begin
                    d.held = 1'b0;
                    d.busy = 1'b0;
                    d.sq   = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sq: SQ_IDLE, cnt: '0, addr: '0, pay: '0, busy: 1'b0,
                   err: 1'b0, cmp: 1'b0, held: 1'b0, idx: '0, bitn: '0,
                   sh: '0, issue: 1'b0, op: OP_BIT, tx: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_W'(REG_COUNT))  reg_rdata = 8'(q.cnt);
        if (reg_addr == ADDR_W'(REG_STATUS)) reg_rdata = {4'b0, q.cmp, q.err, 1'b0, q.busy};
        if (reg_addr == ADDR_W'(REG_ADDR))   reg_rdata = q.addr;
        for (int i = 0; i < NBYTES; i++) begin
            if (reg_addr == ADDR_W'(REG_DATA0 + i)) reg_rdata = q.pay[i];
        end
    end

    // observation points for the bound checker
    logic          st_busy, st_err;
    logic [IW-1:0] st_cnt, st_idx;
    logic [7:0]    st_addr;
    assign st_busy = q.busy;
    assign st_err  = q.err;
    assign st_cnt  = q.cnt;
    assign st_idx  = q.idx;
    assign st_addr = q.addr;
endmodule

// File: rtl/i2cb_master_chk.sv
module i2cb_master_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_en_wr,
    input logic          busy,
    input logic          err,
    input logic [IW-1:0] cnt,
    input logic [IW-1:0] idx,
    input logic [7:0]    addr_reg,
    input logic          cond,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          scl_i
);
    // R7: busy only rises in answer to an enabled control write
    a_r7_busy_from_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_en_wr));

    // R7: length and target stay frozen while the engine runs
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cnt) && $stable(addr_reg)));

    // R9: a fault ends the burst
    a_r9_fault_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);

    // R2: the byte index never passes the programmed length
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= cnt));

    // R12: SDA moves under a high SCL only for start or stop
    a_r12_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && scl_i && $past(!scl_oe && scl_i) && (sda_oe != $past(sda_oe)))
        |-> $past(cond));
endmodule

bind i2cb_master i2cb_master_chk #(.IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en_wr (ctrl_en_wr),
    .busy       (st_busy),
    .err        (st_err),
    .cnt        (st_cnt),
    .idx        (st_idx),
    .addr_reg   (st_addr),
    .cond       (phy_cond),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .scl_i      (scl_i)
);

// File: tb/tb_i2cb_master.sv
module tb_i2cb_master;
    localparam int QUARTER = 4;
    localparam int SLV = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'd1;
    logic [7:0] reg_wdata = 8'h00;
    wire  [7:0] reg_rdata;
    wire        scl_oe, sda_oe;
    logic       slv_low = 1'b0;
    wire        scl_line = !scl_oe;
    wire        sda_line = !(sda_oe || slv_low);

    always #10 clk = ~clk;

    i2cb_master #(.NBYTES(16), .QUARTER(QUARTER), .ADDR_W(5)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input int i);
        return 8'h3C ^ 8'(i * 29);
    endfunction

    // ---------------- device model on the bus ----------------
    int   bitn = -1;
    bit   active = 0, tx = 0, is_addr = 0, acked = 0, rw = 0, macked = 0;
    logic [7:0] sh = 8'h00;
    int   bidx = 0, nack_at = -1;
    logic [7:0] wr_bytes [0:63];
    int   wr_n = 0;
    bit   rd_ack [0:63];
    int   rd_n = 0, start_n = 0, stop_n = 0;
    time  last_pos = 0, per_meas = 0;

    always @(negedge sda_line) if (scl_line === 1'b1) begin
        start_n++; active = 1; is_addr = 1; tx = 0; bitn = -1; bidx = 0; slv_low = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) begin
        stop_n++; active = 0; slv_low = 0;
    end
    always @(posedge scl_line) begin
        if (active && bitn >= 1 && bitn <= 7) per_meas = $time - last_pos;
        last_pos = $time;
        if (active) begin
            if (bitn >= 0 && bitn < 8 && !tx) sh = {sh[6:0], sda_line};
            else if (bitn == 8 && tx) begin
                macked = !sda_line;
                rd_ack[rd_n] = macked; rd_n++;
            end
        end
    end
    always @(negedge scl_line) if (active) begin
        if (bitn < 7) begin
            bitn++;
            slv_low = tx ? !sh[7-bitn] : 1'b0;
        end else if (bitn == 7) begin
            bitn = 8;
            if (!tx) begin
                if (is_addr) begin
                    acked = (sh[7:1] == 7'(SLV)); rw = sh[0];
                end else begin
                    wr_bytes[wr_n] = sh; wr_n++;
                    acked = (bidx != nack_at); bidx++;
                end
                slv_low = acked;
            end else slv_low = 0;
        end else begin
            bitn = 0;
            if (!tx) begin
                if (!acked) begin active = 0; slv_low = 0; end
                else if (is_addr && rw) begin
                    is_addr = 0; tx = 1; bidx = 0; sh = rdb(0); slv_low = !sh[7];
                end else begin is_addr = 0; slv_low = 0; end
            end else if (macked) begin
                bidx++; sh = rdb(bidx); slv_low = !sh[7];
            end else begin active = 0; slv_low = 0; end
        end
    end

    // ---------------- reference model of the register image ----------------
    logic [7:0] m_pay [0:15];
    int m_cnt = 0, m_addr = 0, m_cmp = 0, m_err = 0;

    task automatic wr(input int a, input int dv);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(dv);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 5'd1;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 v = reg_rdata;
    endtask

    task automatic mwr(input int a, input int dv);
        wr(a, dv);
        if (a == 0) m_cnt = dv & 15;
        if (a == 3) m_addr = dv & 255;
        if (a >= 4 && a < 20) m_pay[a-4] = 8'(dv);
        if (a == 2 && !dv[2]) m_err = 0;
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        int n = 0;
        do begin rd(1, v); n++; end while (v[0] && n < 20000);
        chk({tag, " busy drops"}, int'(v[0]), 0);
    endtask

    task automatic cmp_all(input string tag);
        logic [7:0] v;
        rd(0, v); chk({tag, " length"}, v, m_cnt);
        rd(1, v); chk({tag, " status"}, v, (m_cmp << 3) | (m_err << 2));
        rd(3, v); chk({tag, " target"}, v, m_addr);
        for (int i = 0; i < 16; i++) begin
            rd(4 + i, v); chk({tag, " payload"}, v, m_pay[i]);
        end
    endtask

    task automatic burst(input string tag);
        logic [7:0] v;
        wr(2, 8'h05);
        rd(1, v); chk({tag, " R7 busy after launch"}, int'(v[0]), 1);
        wait_idle(tag);
        if (m_addr[7:1] != SLV) m_err = 1;
        else if (!m_addr[0] && nack_at >= 0 && nack_at <= m_cnt) m_err = 1;
        else begin
            m_cmp = 1; m_err = 0;
            if (m_addr[0]) for (int i = 0; i <= m_cnt; i++) m_pay[i] = rdb(i);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int w0, s0, p0;
        for (int i = 0; i < 16; i++) m_pay[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image and released lines
        cmp_all("R1 reset");
        chk("R1 scl released", int'(scl_line), 1);
        chk("R1 sda released", int'(sda_line), 1);

        // R2 length truncation, R3 target, R4 payload and unmapped reads
        mwr(0, 8'hF3); rd(0, v); chk("R2 length low bits", v, 8'h03);
        mwr(3, 8'hA1); rd(3, v); chk("R3 target readback", v, 8'hA1);
        mwr(4, 8'h5A); rd(4, v); chk("R4 payload readback", v, 8'h5A);
        rd(2, v);  chk("R4 offset 0x02 reads zero", v, 0);
        rd(20, v); chk("R4 offset 0x14 reads zero", v, 0);
        rd(31, v); chk("R4 offset 0x1F reads zero", v, 0);

        // R5/R6 write burst of 3 bytes, R7 ignored writes while busy
        mwr(3, 8'hA0); mwr(0, 2);
        mwr(4, 8'h11); mwr(5, 8'h22); mwr(6, 8'h33);
        w0 = wr_n; s0 = start_n;
        wr(2, 8'h05);
        rd(1, v); chk("R7 busy after launch", int'(v[0]), 1);
        wr(4, 8'hEE); wr(0, 8'h07); wr(3, 8'h12); wr(2, 8'h01);
        wait_idle("R7");
        m_cmp = 1; m_err = 0;
        chk("R2 byte count on bus", wr_n - w0, 3);
        chk("R5 start seen", start_n - s0, 1);
        chk("R5 byte 0", wr_bytes[w0], 8'h11);
        chk("R5 byte 2", wr_bytes[w0+2], 8'h33);
        rd(1, v); chk("R6 status after success", v, 8'h08);
        chk("R12 bit spacing ns", int'(per_meas), (4*QUARTER+2)*20);
        cmp_all("R7 writes ignored");

        // R10 stop from held bus
        p0 = stop_n; mwr(2, 8'h01); wait_idle("R10");
        chk("R10 stop generated", stop_n - p0, 1);

        // R8 read burst of 4 bytes
        mwr(3, 8'hA1); mwr(0, 3); p0 = rd_n;
        burst("R8");
        cmp_all("R8 read data");
        chk("R8 ack byte 0", int'(rd_ack[p0]), 1);
        chk("R8 ack byte 2", int'(rd_ack[p0+2]), 1);
        chk("R8 nack last", int'(rd_ack[p0+3]), 0);
        mwr(2, 8'h01); wait_idle("R10 b");

        // R9 address not acknowledged, R11 fault clearing
        mwr(3, 8'h44); mwr(0, 1); w0 = wr_n; p0 = stop_n;
        burst("R9 addr");
        rd(1, v); chk("R9 status after address nack", v, 8'h0C);
        chk("R9 no payload sent", wr_n - w0, 0);
        chk("R9 no stop", stop_n - p0, 0);
        mwr(2, 8'h04); rd(1, v); chk("R11 bit2 set keeps fault", v, 8'h0C);
        mwr(2, 8'h00); rd(1, v); chk("R11 bit2 clear clears fault", v, 8'h08);
        mwr(2, 8'h01); wait_idle("R10 c");
        chk("R10 stop after nack", stop_n - p0, 1);

        // R9 data byte 1 not acknowledged in a 4 byte write, R10 clears fault
        mwr(3, 8'hA0); mwr(0, 3); nack_at = 1; w0 = wr_n;
        burst("R9 data");
        nack_at = -1;
        chk("R9 bytes before abort", wr_n - w0, 2);
        cmp_all("R9 data");
        p0 = stop_n; mwr(2, 8'h01); wait_idle("R10 d");
        rd(1, v); chk("R10 stop clears fault", v, 8'h08);
        chk("R10 stop after data nack", stop_n - p0, 1);

        // R2 full 16 byte write
        for (int i = 0; i < 16; i++) mwr(4 + i, 8'(8'hC0 + i));
        mwr(0, 8'h0F); w0 = wr_n;
        burst("R2 full");
        chk("R2 sixteen bytes", wr_n - w0, 16);
        chk("R2 last byte", wr_bytes[w0+15], 8'hCF);

        // R5 repeated start from held bus into a 1 byte read
        mwr(3, 8'hA1); mwr(0, 0); s0 = start_n; p0 = stop_n;
        burst("R5 restart");
        chk("R5 repeated start", start_n - s0, 1);
        chk("R5 no stop between", stop_n - p0, 0);
        cmp_all("R5 restart");
        mwr(2, 8'h01); wait_idle("R10 e");

        // R10 release on idle bus does nothing on the wires
        p0 = stop_n; s0 = start_n;
        mwr(2, 8'h01);
        rd(1, v); chk("R10 idle release not busy", int'(v[0]), 0);
        repeat (40) @(negedge clk);
        chk("R10 idle release no stop", stop_n - p0, 0);
        chk("R10 idle release no start", start_n - s0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule